// File: doc/BRIEF.md
# Adaptive Equalizer Search Controller

This controller picks an equalizer code for one receiver lane by running a series of hit-count measurements through an external counter. Each measurement is a request carrying an EQ code, a DAC VOD offset magnitude and a polarity bit. The counter answers with an acknowledge and a hit count. The analog eye measurement sits entirely behind that request/acknowledge port.

In the full search mode, the block first takes a reference mid-eye count at a programmed EQ code. From that count it derives two thresholds by fixed-point scaling. It then runs a downward VOD sweep for the positive polarity, followed by an upward EQ sweep at the VOD offset found. The same two sweeps are repeated for the negative polarity. The two EQ results are combined into one by max or min. Two lighter modes skip the VOD sweeps and sweep EQ only at zero offset. One of them uses a single reference count; the other updates its reference on every iteration. The fast mode is not searched here: it returns the programmed code at once.

The block is started with a one-cycle pulse. All configuration is captured at that moment. When the result is ready, the block raises a one-cycle done strobe and holds the result until the next completion.

Top module: `aeq_search_ctrl`

## Requirements
- R1: A start pulse is accepted only while no search is running; a start that arrives during a search causes neither a second search nor a second done strobe.
- R2: In modes 2 and 3, the first measurement request uses the captured mid-eye code, VOD offset 0 and positive polarity (`meas_neg_o` = 0). Its count becomes the reference.
- R3: The VOD threshold is (reference × `vod_frac_i`) >> 7. The VOD sweep runs at the mid-eye code from offset 7 downward and stops at the first offset whose count is at or above this threshold. Offset 0 is taken when no larger offset passes.
- R4: The EQ threshold is (reference × (128 − `eq_frac_i`)) >> 7. The EQ sweep starts at code 0 and counts upward, and selects the first code whose count is at or above this threshold.
- R5: When no code from 0 up to `upper_eq_i` reaches the EQ threshold, the result is `upper_eq_i`.
- R6: Mode 2 runs its VOD and EQ sweeps with polarity 0 and then again with polarity 1. The result is the larger of the two EQ codes when `merge_min_i` = 0 and the smaller when it is 1.
- R7: Mode 3 takes a single reference capture and then runs the EQ sweep at offset 0 with polarity 0. Its result is that sweep's code, with no merge.
- R8: Mode 1 takes no separate capture. Each EQ iteration measures at offset 0 with polarity 0, and that count becomes the reference for the next code. Code 0 never qualifies. The result is the smallest code ≥ 1 whose count is ≥ (previous count × (128 − `eq_frac_i`)) >> 7, or `upper_eq_i` when no code qualifies.
- R9: Mode 0 issues no measurement requests. It completes one cycle after start, with the result equal to `mid_eq_i`.
- R10: `meas_req_o` stays high, and the EQ code, offset and polarity stay stable, until a cycle in which `meas_ack_i` is high. The count is taken in that cycle.
- R11: After reset, `result_o`, `done_o` and `meas_req_o` are 0. `done_o` is high for exactly one cycle per search. `result_o` keeps its value until the next done strobe.
- R12: Mode, codes, fractions, bound and merge select are captured at start. Changing them during a search does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Search start pulse |
| mode_i | input | 2 | 0 fast, 1 per-iteration reference, 2 full search, 3 single reference |
| mid_eq_i | input | 4 | EQ code for the mid-eye capture (typically 7) |
| upper_eq_i | input | 4 | Highest EQ code tried (typically 8) |
| vod_frac_i | input | 4 | VOD threshold fraction in 1/128 steps (typically 6) |
| eq_frac_i | input | 3 | EQ threshold reduction in 1/128 steps (typically 4) |
| merge_min_i | input | 1 | 0 keeps the larger polarity result, 1 the smaller |
| meas_req_o | output | 1 | Measurement request |
| meas_eq_o | output | 4 | EQ code for the measurement |
| meas_vod_o | output | 3 | DAC VOD offset magnitude |
| meas_neg_o | output | 1 | VOD offset polarity, 1 negative |
| meas_ack_i | input | 1 | Measurement complete, count valid |
| meas_cnt_i | input | 16 | Measured hit count |
| result_o | output | 4 | Selected EQ code |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hit counter is modelled as an eye whose count falls with distance from a random optimum code and falls with VOD offset at a rate that shrinks as EQ rises. Separate slopes per polarity make the two merge choices give different codes. Random configurations in all four modes, run with random acknowledge latency, separate the sweep direction, the early stop and the polarity order. Directed cases cover the remaining edges: a count exactly equal to the mode-1 threshold, which must pass; a bound below the optimum, which must fall back to the bound; and a reconfiguration plus restart in mid-search, which must leave the result unchanged.

// File: rtl/aeq_pkg.sv
package aeq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MID,
    ST_VOD,
    ST_EQ
  } state_e;

  typedef enum logic [1:0] {
    MODE_FAST   = 2'd0,
    MODE_EVERY  = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_FIRST  = 2'd3
  } mode_e;
endpackage

// File: rtl/aeq_thresh.sv
module aeq_thresh #(
  parameter int unsigned CW    = 16,
  parameter int unsigned VFW   = 4,
  parameter int unsigned EFW   = 3,
  parameter int unsigned SHIFT = 7
) (
  input  logic [CW-1:0]  ref_i,
  input  logic [VFW-1:0] vfrac_i,
  input  logic [EFW-1:0] efrac_i,
  output logic [CW-1:0]  vthr_o,
  output logic [CW-1:0]  ethr_o
);
  localparam int unsigned PW = CW + SHIFT + 1;
  localparam logic [SHIFT:0] FULL = {1'b1, {SHIFT{1'b0}}};

  logic [SHIFT:0] keep;
  logic [PW-1:0]  ref_x, vprod, eprod;

  assign keep   = FULL - {{(SHIFT + 1 - EFW){1'b0}}, efrac_i};
  assign ref_x  = {{(PW - CW){1'b0}}, ref_i};
  assign vprod  = ref_x * {{(PW - VFW){1'b0}}, vfrac_i};
  assign eprod  = ref_x * {{(PW - SHIFT - 1){1'b0}}, keep};
  // truncating scale by 1/2^SHIFT
  assign vthr_o = CW'(vprod >> SHIFT);
  assign ethr_o = CW'(eprod >> SHIFT);
endmodule

// File: rtl/aeq_merge.sv
module aeq_merge #(
  parameter int unsigned EQW = 4
) (
  input  logic [EQW-1:0] pos_i,
  input  logic [EQW-1:0] neg_i,
  input  logic           min_sel_i,
  output logic [EQW-1:0] eq_o
);
  logic pos_gt;
  assign pos_gt = pos_i > neg_i;
  assign eq_o   = (pos_gt ^ min_sel_i) ? pos_i : neg_i;
endmodule

// File: rtl/aeq_search_ctrl.sv
module aeq_search_ctrl
  import aeq_pkg::*;
#(
  parameter int unsigned EQW  = 4,
  parameter int unsigned VODW = 3,
  parameter int unsigned CW   = 16,
  parameter int unsigned VFW  = 4,
  parameter int unsigned EFW  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic [EQW-1:0]  mid_eq_i,
  input  logic [EQW-1:0]  upper_eq_i,
  input  logic [VFW-1:0]  vod_frac_i,
  input  logic [EFW-1:0]  eq_frac_i,
  input  logic            merge_min_i,
  output logic            meas_req_o,
  output logic [EQW-1:0]  meas_eq_o,
  output logic [VODW-1:0] meas_vod_o,
  output logic            meas_neg_o,
  input  logic            meas_ack_i,
  input  logic [CW-1:0]   meas_cnt_i,
  output logic [EQW-1:0]  result_o,
  output logic            done_o
);
  localparam logic [VODW-1:0] VOD_MAX = {VODW{1'b1}};

  state_e          state_q;
  mode_e           mode_q;
  logic [EQW-1:0]  mid_q, upper_q, eq_q, eq_pos_q, result_q;
  logic [VFW-1:0]  vfrac_q;
  logic [EFW-1:0]  efrac_q;
  logic            mmin_q, neg_q, first_q, done_q;
  logic [VODW-1:0] vod_q;
  logic [CW-1:0]   ref_q;

  logic [CW-1:0]   vthr, ethr;
  logic [EQW-1:0]  merged;
  logic            vod_pass, eq_pass, eq_stop;

  aeq_thresh #(.CW(CW), .VFW(VFW), .EFW(EFW), .SHIFT(7)) i_thresh (
    .ref_i   (ref_q),
    .vfrac_i (vfrac_q),
    .efrac_i (efrac_q),
    .vthr_o  (vthr),
    .ethr_o  (ethr)
  );

  aeq_merge #(.EQW(EQW)) i_merge (
    .pos_i     (eq_pos_q),
    .neg_i     (eq_q),
    .min_sel_i (mmin_q),
    .eq_o      (merged)
  );

  assign vod_pass = (meas_cnt_i >= vthr) || (vod_q == '0);
  // mode 1 has no reference before its first iteration
  assign eq_pass  = (meas_cnt_i >= ethr) && !((mode_q == MODE_EVERY) && first_q);
  assign eq_stop  = eq_pass || (eq_q == upper_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_FAST;
      mid_q    <= '0;
      upper_q  <= '0;
      vfrac_q  <= '0;
      efrac_q  <= '0;
      mmin_q   <= 1'b0;
      eq_q     <= '0;
      vod_q    <= '0;
      neg_q    <= 1'b0;
      first_q  <= 1'b0;
      ref_q    <= '0;
      eq_pos_q <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= mode_e'(mode_i);
            mid_q   <= mid_eq_i;
            upper_q <= upper_eq_i;
            vfrac_q <= vod_frac_i;
            efrac_q <= eq_frac_i;
            mmin_q  <= merge_min_i;
            neg_q   <= 1'b0;
            first_q <= 1'b1;
            vod_q   <= '0;
            unique case (mode_e'(mode_i))
              MODE_FAST: begin
                result_q <= mid_eq_i;
                done_q   <= 1'b1;
              end
              MODE_EVERY: begin
                eq_q    <= '0;
                state_q <= ST_EQ;
              end
              default: begin
                eq_q    <= mid_eq_i;
                state_q <= ST_MID;
              end
            endcase
          end
        end
        ST_MID: begin
          if (meas_ack_i) begin
            ref_q <= meas_cnt_i;
            if (mode_q == MODE_SEARCH) begin
              vod_q   <= VOD_MAX;
              state_q <= ST_VOD;
            end else begin
              eq_q    <= '0;
              state_q <= ST_EQ;
            end
          end
        end
        ST_VOD: begin
          if (meas_ack_i) begin
            if (vod_pass) begin
              eq_q    <= '0;
              state_q <= ST_EQ;
            end else begin
              vod_q <= vod_q - 1'b1;
            end
          end
        end
        ST_EQ: begin
          if (meas_ack_i) begin
            if (mode_q == MODE_EVERY) begin
              ref_q   <= meas_cnt_i;
              first_q <= 1'b0;
            end
            if (eq_stop) begin
              if ((mode_q == MODE_SEARCH) && !neg_q) begin
                eq_pos_q <= eq_q;
                neg_q    <= 1'b1;
                eq_q     <= mid_q;
                vod_q    <= VOD_MAX;
                state_q  <= ST_VOD;
              end else begin
                result_q <= (mode_q == MODE_SEARCH) ? merged : eq_q;
                done_q   <= 1'b1;
                state_q  <= ST_IDLE;
              end
            end else begin
              eq_q <= eq_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign meas_req_o = (state_q != ST_IDLE);
  assign meas_eq_o  = eq_q;
  assign meas_vod_o = vod_q;
  assign meas_neg_o = neg_q;
  assign result_o   = result_q;
  assign done_o     = done_q;
endmodule

// File: rtl/aeq_search_chk.sv
module aeq_search_chk
  import aeq_pkg::*;
#(
  parameter int unsigned EQW  = 4,
  parameter int unsigned VODW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            meas_req_o,
  input logic            meas_ack_i,
  input logic [EQW-1:0]  meas_eq_o,
  input logic [VODW-1:0] meas_vod_o,
  input logic            meas_neg_o,
  input logic            done_o,
  input logic [EQW-1:0]  result_o,
  input mode_e           mode_q,
  input logic            mmin_q,
  input logic [EQW-1:0]  eq_pos_q,
  input logic [EQW-1:0]  upper_q
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o && !meas_ack_i |=> meas_req_o && $stable(meas_eq_o) &&
                                  $stable(meas_vod_o) && $stable(meas_neg_o));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !meas_req_o);

  p_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_q != MODE_FAST) |-> result_o <= upper_q);

  p_merge_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_q == MODE_SEARCH) && mmin_q |-> result_o <= eq_pos_q);

  p_merge_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_q == MODE_SEARCH) && !mmin_q |-> result_o >= eq_pos_q);

  p_zero_vod_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o && (mode_q == MODE_FIRST) |-> (meas_vod_o == '0) && !meas_neg_o);

  p_zero_vod_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o && (mode_q == MODE_EVERY) |-> (meas_vod_o == '0) && !meas_neg_o);
endmodule

bind aeq_search_ctrl aeq_search_chk #(.EQW(EQW), .VODW(VODW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .meas_req_o (meas_req_o),
  .meas_ack_i (meas_ack_i),
  .meas_eq_o  (meas_eq_o),
  .meas_vod_o (meas_vod_o),
  .meas_neg_o (meas_neg_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .mode_q     (mode_q),
  .mmin_q     (mmin_q),
  .eq_pos_q   (eq_pos_q),
  .upper_q    (upper_q)
);

// File: tb/test_aeq_search_ctrl.sv
module test_aeq_search_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [3:0]  mid_eq_i = '0;
  logic [3:0]  upper_eq_i = '0;
  logic [3:0]  vod_frac_i = '0;
  logic [2:0]  eq_frac_i = '0;
  logic        merge_min_i = 1'b0;
  logic        meas_req_o;
  logic [3:0]  meas_eq_o;
  logic [2:0]  meas_vod_o;
  logic        meas_neg_o;
  logic        meas_ack_i = 1'b0;
  logic [15:0] meas_cnt_i = '0;
  logic [3:0]  result_o;
  logic        done_o;

  int n_chk = 0, n_bad = 0;
  int m_opt, m_peak, m_drop, m_sp, m_sn;
  int done_cnt, n_req, hold_err, first_eq, first_vod, first_neg;
  int nz_flag, saw_neg, last_pos_vod, wcnt;
  logic pend;
  logic [3:0] p_eq;
  logic [2:0] p_vod;
  logic p_neg;

  always #5 clk_i = ~clk_i;

  aeq_search_ctrl i_aeq_search_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .mid_eq_i(mid_eq_i), .upper_eq_i(upper_eq_i), .vod_frac_i(vod_frac_i),
    .eq_frac_i(eq_frac_i), .merge_min_i(merge_min_i), .meas_req_o(meas_req_o),
    .meas_eq_o(meas_eq_o), .meas_vod_o(meas_vod_o), .meas_neg_o(meas_neg_o),
    .meas_ack_i(meas_ack_i), .meas_cnt_i(meas_cnt_i), .result_o(result_o),
    .done_o(done_o)
  );

  function automatic int hc(int e, int v, int n);
    int d, c;
    d = (e > m_opt) ? e - m_opt : m_opt - e;
    c = m_peak - m_drop * d - (v * ((n != 0) ? m_sn : m_sp)) / (1 + e);
    return (c < 0) ? 0 : c;
  endfunction

  function automatic int vsel(int mid, int vt, int n);
    int nv, v;
    nv = (hc(mid, 0, 0) * vt) >> 7;
    v = 7;
    while (v > 0 && hc(mid, v, n) < nv) v--;
    return v;
  endfunction

  function automatic int esel(int v, int n, int up, int ne);
    for (int e = 0; e <= up; e++) if (hc(e, v, n) >= ne) return e;
    return up;
  endfunction

  function automatic int ref_result(int md, int mid, int up, int vt, int et, int mm);
    int prev, c, ne, p, q;
    if (md == 0) return mid;
    if (md == 1) begin
      prev = hc(0, 0, 0);
      for (int e = 1; e <= up; e++) begin
        c = hc(e, 0, 0);
        if (c >= ((prev * (128 - et)) >> 7)) return e;
        prev = c;
      end
      return up;
    end
    ne = (hc(mid, 0, 0) * (128 - et)) >> 7;
    if (md == 3) return esel(0, 0, up, ne);
    p = esel(vsel(mid, vt, 0), 0, up, ne);
    q = esel(vsel(mid, vt, 1), 1, up, ne);
    if (mm != 0) return (p < q) ? p : q;
    return (p > q) ? p : q;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // hit counter model with random acknowledge latency
  initial begin
    pend = 1'b0;
    wcnt = 0;
    forever begin
      @(negedge clk_i);
      if (done_o) done_cnt++;
      if (meas_ack_i) begin
        meas_ack_i = 1'b0;
        pend = 1'b0;
      end else if (meas_req_o) begin
        if (pend && (meas_eq_o != p_eq || meas_vod_o != p_vod || meas_neg_o != p_neg))
          hold_err++;
        pend = 1'b1;
        p_eq = meas_eq_o; p_vod = meas_vod_o; p_neg = meas_neg_o;
        if (wcnt == 0) begin
          meas_cnt_i = 16'(hc(int'(meas_eq_o), int'(meas_vod_o), int'(meas_neg_o)));
          meas_ack_i = 1'b1;
          n_req++;
          if (n_req == 1) begin
            first_eq = int'(meas_eq_o); first_vod = int'(meas_vod_o); first_neg = int'(meas_neg_o);
          end
          if (meas_vod_o != 0 || meas_neg_o) nz_flag = 1;
          if (meas_neg_o) saw_neg = 1;
          else last_pos_vod = int'(meas_vod_o);
          wcnt = int'($urandom % 3);
        end else wcnt--;
      end
    end
  end

  task automatic run_case(input int md, input int mid, input int up, input int vt,
                          input int et, input int mm, input bit scramble);
    int exp_r, exp_v, tmo, got;
    string rtag;
    exp_r = ref_result(md, mid, up, vt, et, mm);
    exp_v = vsel(mid, vt, 0);
    rtag = (md == 0) ? "R9 fast result" : (md == 1) ? "R8 per-iteration result" :
           (md == 2) ? "R4/R6 full search result" : "R7/R4 single-reference result";
    @(negedge clk_i);
    mode_i = 2'(md); mid_eq_i = 4'(mid); upper_eq_i = 4'(up);
    vod_frac_i = 4'(vt); eq_frac_i = 3'(et); merge_min_i = mm[0];
    done_cnt = 0; n_req = 0; hold_err = 0; nz_flag = 0; saw_neg = 0;
    last_pos_vod = -1; first_eq = -1; first_vod = -1; first_neg = -1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (scramble && md != 0) begin
      mode_i = 2'($urandom); mid_eq_i = 4'($urandom); upper_eq_i = 4'($urandom);
      vod_frac_i = 4'($urandom); eq_frac_i = 3'($urandom); merge_min_i = 1'($urandom);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    tmo = 0;
    while (!done_o && tmo < 4000) begin
      @(negedge clk_i);
      tmo++;
    end
    got = int'(result_o);
    chk(done_o == 1'b1, "R11 done seen", int'(done_o), 1);
    chk(got == exp_r, scramble ? {rtag, " R12 reconfigured"} : rtag, got, exp_r);
    repeat (6) @(negedge clk_i);
    chk(done_cnt == 1, scramble ? "R1 single done after restart" : "R11 single done", done_cnt, 1);
    chk(meas_req_o == 1'b0, "R1 no search after done", int'(meas_req_o), 0);
    chk(int'(result_o) == got, "R11 result held", int'(result_o), got);
    chk(hold_err == 0, "R10 request stable until ack", hold_err, 0);
    if (md == 2 || md == 3) begin
      chk(first_eq == mid && first_vod == 0 && first_neg == 0, "R2 mid-eye capture request",
          first_eq * 100 + first_vod * 10 + first_neg, mid * 100);
    end
    if (md == 2) begin
      chk(saw_neg == 1, "R6 negative pass run", saw_neg, 1);
      chk(last_pos_vod == exp_v, "R3 positive VOD choice", last_pos_vod, exp_v);
    end
    if (md == 1 || md == 3)
      chk(nz_flag == 0, (md == 1) ? "R8 zero offset only" : "R7 zero offset only", nz_flag, 0);
    if (md == 0) chk(n_req == 0, "R9 no requests", n_req, 0);
  endtask

  task automatic set_model(input int opt, input int peak, input int drop, input int sp, input int sn);
    m_opt = opt; m_peak = peak; m_drop = drop; m_sp = sp; m_sn = sn;
  endtask

  initial begin
    void'($urandom(32'd4711));
    set_model(7, 1000, 20, 50, 50);
    repeat (3) @(negedge clk_i);
    chk(result_o == '0, "R11 reset result", int'(result_o), 0);
    chk(done_o == 1'b0, "R11 reset done", int'(done_o), 0);
    chk(meas_req_o == 1'b0, "R11 reset request", int'(meas_req_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R9 fast mode
    run_case(0, 9, 8, 6, 4, 0, 1'b0);
    // R5 bound below optimum: nothing passes
    set_model(12, 1000, 30, 50, 50);
    run_case(3, 12, 5, 6, 0, 0, 1'b0);
    chk(int'(result_o) == 5, "R5 fallback to bound", int'(result_o), 5);
    // R6 asymmetric polarities, max then min
    set_model(3, 1200, 10, 10, 300);
    run_case(2, 7, 15, 6, 4, 0, 1'b0);
    run_case(2, 7, 15, 6, 4, 1, 1'b0);
    // R8 count equal to threshold passes: 1000*123>>7 = 960
    set_model(0, 1000, 40, 50, 50);
    run_case(1, 7, 8, 6, 5, 0, 1'b0);
    chk(int'(result_o) == 1, "R8 equality at threshold", int'(result_o), 1);
    // R12 reconfiguration and restart mid-search
    set_model(5, 900, 15, 40, 120);
    run_case(2, 7, 8, 6, 4, 0, 1'b1);

    for (int i = 0; i < 60; i++) begin
      set_model(int'($urandom % 16), 700 + int'($urandom % 800), int'($urandom % 41),
                10 + int'($urandom % 390), 10 + int'($urandom % 390));
      run_case(int'($urandom % 4), int'($urandom % 16), int'($urandom % 16),
               int'($urandom % 16), int'($urandom % 8), int'($urandom % 2),
               1'($urandom % 3 == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule